// File: doc/BRIEF.md
# Thermal Limit Alert Logic

This block turns each finished temperature conversion into the level of an alert output. The temperature and the two limits are 12-bit two's-complement values with 0.0625 °C per LSB. The block compares every new result against the high limit and the low limit. A conversion that meets the condition currently being watched counts as a fault. A programmable run of consecutive faults is needed before the alert changes state, so that one noisy sample does not toggle it.

In comparator mode the alert works as a thermostat with hysteresis. It asserts after enough conversions at or above the high limit and releases after enough conversions below the low limit. In interrupt mode the alert latches once the threshold is reached and stays active until a register read or a won alert-response reply clears it. After a clear, the block watches the opposite threshold. A cause bit records which threshold produced the alert, for use in the alert-response reply. Entering shutdown clears the alert. A general-call reset clears the alert and returns the block to watching the high limit.

Top module: `thermal_limit_alert`

## Requirements
- R1: After reset the alert is inactive, the cause bit is 0, and the fault count is zero, so `alert_pin` reads 1 when `pol_high` is 0.
- R2: `fault_sel` selects how many consecutive conversions that meet the watched condition are needed before the alert changes: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6. A conversion that does not meet the condition restarts the count from zero.
- R3: When `mode_intr` is 0 and the alert is inactive, a conversion with `temp` greater than or equal to `hi_lim` counts as a fault, and the alert asserts when the count is reached.
- R4: When `mode_intr` is 0 and the alert is active, only conversions with `temp` strictly below `lo_lim` count as faults. A value between the limits leaves the alert unchanged.
- R5: When `mode_intr` is 1, the alert asserts after the count is reached at or above `hi_lim`. It then stays active until a cycle with `reg_read` or `ara_win` set, after which it is inactive.
- R6: After an interrupt-mode clear, only conversions below `lo_lim` can raise the alert again. Once that alert is cleared, the block watches `hi_lim` again.
- R7: In comparator mode, `reg_read` and `ara_win` have no effect on the alert or the cause bit.
- R8: `alert_pin` is active low when `pol_high` is 0 and active high when `pol_high` is 1.
- R9: A cycle where `shutdown` goes from 0 to 1 clears the alert.
- R10: `gc_reset` clears the alert, the cause bit and the fault count, and returns the block to watching the high limit.
- R11: The comparisons are signed and use all 12 bits. For example 0x004 (+0.25 °C) is at or above 0xFFC (−0.25 °C), and 0x500 is below 0x501.
- R12: `alert_cause` is 1 when the last alert event came from the high limit and 0 when it came from the low limit.
- R13: A change of `mode_intr` resets the fault count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: a new result is on `temp` |
| temp | input | 12 | Conversion result, two's complement |
| hi_lim | input | 12 | High limit, two's complement |
| lo_lim | input | 12 | Low limit, two's complement |
| mode_intr | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| pol_high | input | 1 | 1 = alert pin active high |
| fault_sel | input | 2 | Selects the consecutive-fault count |
| shutdown | input | 1 | Shutdown setting, cleared on entry |
| reg_read | input | 1 | Strobe: a register was read |
| ara_win | input | 1 | Strobe: alert-response reply won |
| gc_reset | input | 1 | Strobe: general-call reset |
| alert_pin | output | 1 | Alert level after the polarity is applied |
| alert_cause | output | 1 | 1 = high limit, 0 = low limit |

## Verification
Every strobe or conversion sampled at a rising edge updates the alert state in that same edge. `alert_pin` and `alert_cause` therefore show the result one cycle after the stimulus. A change of `pol_high` appears on the pin with no extra register. The driver changes inputs on the falling edge and queues the expected pin and cause level for that cycle. The monitor takes each item shortly after the following rising edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

  // maximum consecutive faults any code can ask for
  localparam int unsigned MAX_FAULTS = 6;
  localparam int unsigned CNT_W      = $clog2(MAX_FAULTS + 1);

  typedef enum logic {WATCH_HIGH = 1'b0, WATCH_LOW = 1'b1} watch_e;

  // code -> number of consecutive faulting conversions required
  function automatic logic [CNT_W-1:0] faults_needed(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    unique case (code)
      2'd0:    n = CNT_W'(1);
      2'd1:    n = CNT_W'(2);
      2'd2:    n = CNT_W'(4);
      default: n = CNT_W'(6);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tla_limit_cmp.sv
module tla_limit_cmp #(
  parameter int unsigned TW = 12
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  output logic          at_or_above_hi,
  output logic          below_lo
);
  // signed comparisons over the full width, independent of resolution
  assign at_or_above_hi = $signed(temp) >= $signed(hi_lim);
  assign below_lo       = $signed(temp) <  $signed(lo_lim);
endmodule

// File: rtl/tla_fault_queue.sv
module tla_fault_queue
  import thermal_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             cond,
  input  logic [CNT_W-1:0] need,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign fire     = step && cond && (next_cnt >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      if (!cond || fire) cnt <= '0;
      else               cnt <= next_cnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tla_alert_fsm.sv
module tla_alert_fsm
  import thermal_alert_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gc_reset,
  input  logic   sd_enter,
  input  logic   mode_chg,
  input  logic   mode_intr,
  input  logic   clr_req,
  input  logic   hot,
  input  logic   cold,
  input  logic   fire,
  output logic   cond,
  output logic   intr_clear,
  output logic   alert_act,
  output logic   alert_cause,
  output watch_e watch
);
  // condition that counts as a fault in the present state
  always_comb begin
    if (mode_intr) cond = !alert_act && ((watch == WATCH_LOW) ? cold : hot);
    else           cond = alert_act ? cold : hot;
  end

  assign intr_clear = mode_intr && alert_act && clr_req
                      && !gc_reset && !sd_enter && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_act   <= 1'b0;
      alert_cause <= 1'b0;
      watch       <= WATCH_HIGH;
    end else if (gc_reset) begin
      alert_act   <= 1'b0;
      alert_cause <= 1'b0;
      watch       <= WATCH_HIGH;
    end else if (sd_enter) begin
      alert_act   <= 1'b0;
    end else if (mode_chg) begin
      watch       <= WATCH_HIGH;
    end else if (intr_clear) begin
      alert_act   <= 1'b0;
      watch       <= (watch == WATCH_LOW) ? WATCH_HIGH : WATCH_LOW;
    end else if (fire) begin
      if (mode_intr) begin
        alert_act   <= 1'b1;
        alert_cause <= (watch == WATCH_HIGH);
      end else begin
        alert_act   <= !alert_act;
        alert_cause <= !alert_act;
      end
    end
  end
endmodule

// File: rtl/thermal_limit_alert.sv
module thermal_limit_alert
  import thermal_alert_pkg::*;
#(
  parameter int unsigned TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  input  logic          mode_intr,
  input  logic          pol_high,
  input  logic [1:0]    fault_sel,
  input  logic          shutdown,
  input  logic          reg_read,
  input  logic          ara_win,
  input  logic          gc_reset,
  output logic          alert_pin,
  output logic          alert_cause
);
  logic             hot, cold, cond, fire, intr_clear;
  logic             alert_act;
  logic             mode_q, sd_q;
  logic             mode_chg, sd_enter, cnt_clr, cnt_step;
  logic [CNT_W-1:0] fault_cnt;
  watch_e           watch;
  logic             watch_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      mode_q <= mode_intr;
      sd_q   <= shutdown;
    end
  end

  assign mode_chg  = mode_intr != mode_q;
  assign sd_enter  = shutdown && !sd_q;
  assign cnt_clr   = gc_reset || sd_enter || mode_chg || intr_clear;
  assign cnt_step  = conv_done && !cnt_clr;
  assign watch_low = (watch == WATCH_LOW);

  tla_limit_cmp #(.TW(TW)) cmp_i (
    .temp(temp), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .at_or_above_hi(hot), .below_lo(cold)
  );

  tla_fault_queue fq_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(cnt_step), .cond(cond),
    .need(faults_needed(fault_sel)), .fire(fire), .cnt(fault_cnt)
  );

  tla_alert_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .sd_enter(sd_enter),
    .mode_chg(mode_chg), .mode_intr(mode_intr), .clr_req(reg_read || ara_win),
    .hot(hot), .cold(cold), .fire(fire), .cond(cond), .intr_clear(intr_clear),
    .alert_act(alert_act), .alert_cause(alert_cause), .watch(watch)
  );

  assign alert_pin = pol_high ? alert_act : !alert_act;
endmodule

// File: rtl/tla_alert_checker.sv
module tla_alert_checker
  import thermal_alert_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic             mode_intr,
  input logic             reg_read,
  input logic             ara_win,
  input logic             gc_reset,
  input logic             alert_act,
  input logic             alert_cause,
  input logic             watch_low,
  input logic             fire,
  input logic             mode_chg,
  input logic             sd_enter,
  input logic [CNT_W-1:0] fault_cnt
);
  // R2: the alert only rises on a completed fault run
  assert_rise_on_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_act) |-> $past(fire));

  // R5: a read clears an active interrupt-mode alert
  assert_intr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_intr && !mode_chg && !gc_reset && alert_act && reg_read) |=> !alert_act);

  // R6: every interrupt-mode clear swaps the watched threshold
  assert_intr_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_intr && !mode_chg && !gc_reset && !sd_enter && alert_act && (reg_read || ara_win))
    |=> (watch_low != $past(watch_low)));

  // R7: read strobes do nothing in comparator mode
  assert_cmp_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_intr && !mode_chg && !gc_reset && !sd_enter && !conv_done && (reg_read || ara_win))
    |=> ($stable(alert_act) && $stable(alert_cause)));

  // R9: entering shutdown clears the alert
  assert_sd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_enter |=> !alert_act);

  // R10: general-call reset restores the initial state
  assert_gc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (!alert_act && !alert_cause && !watch_low && fault_cnt == '0));

  // R13: a mode change restarts the fault count
  assert_mode_cnt_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (fault_cnt == '0));
endmodule

bind thermal_limit_alert tla_alert_checker chk_i (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .mode_intr(mode_intr),
  .reg_read(reg_read), .ara_win(ara_win), .gc_reset(gc_reset),
  .alert_act(alert_act), .alert_cause(alert_cause), .watch_low(watch_low),
  .fire(fire), .mode_chg(mode_chg), .sd_enter(sd_enter), .fault_cnt(fault_cnt)
);

// File: tb/thermal_limit_alert_tb_top.sv
module thermal_limit_alert_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] temp = '0;
  logic [11:0] hi_lim = 12'h500;
  logic [11:0] lo_lim = 12'h4B0;
  logic        mode_intr = 1'b0;
  logic        pol_high = 1'b0;
  logic [1:0]  fault_sel = 2'd0;
  logic        shutdown = 1'b0;
  logic        reg_read = 1'b0;
  logic        ara_win = 1'b0;
  logic        gc_reset = 1'b0;
  logic        alert_pin, alert_cause;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  pin;
    logic  cause;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  bit m_act = 0, m_cause = 0, m_low = 0, m_mode_prev = 0, m_sd_prev = 0;
  int m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  thermal_limit_alert dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .mode_intr(mode_intr), .pol_high(pol_high),
    .fault_sel(fault_sel), .shutdown(shutdown), .reg_read(reg_read),
    .ara_win(ara_win), .gc_reset(gc_reset), .alert_pin(alert_pin),
    .alert_cause(alert_cause)
  );

  function automatic int run_len(input logic [1:0] s);
    int r;
    case (s)
      2'd0: r = 1;
      2'd1: r = 2;
      2'd2: r = 4;
      default: r = 6;
    endcase
    return r;
  endfunction

  // driver: one cycle of stimulus, model update, expectation pushed
  task automatic step(input bit cv, input logic [11:0] t, input bit rd,
                      input bit ar, input bit gc, input string tag);
    exp_t e;
    bit hot, cold, watch_hit;
    conv_done = cv; temp = t; reg_read = rd; ara_win = ar; gc_reset = gc;
    hot  = $signed(t) >= $signed(hi_lim);
    cold = $signed(t) <  $signed(lo_lim);
    if (gc) begin
      m_act = 0; m_cause = 0; m_low = 0; m_cnt = 0;
    end else if (shutdown && !m_sd_prev) begin
      m_act = 0; m_cnt = 0;
    end else if (mode_intr != m_mode_prev) begin
      m_cnt = 0; m_low = 0;
    end else if (mode_intr && m_act && (rd || ar)) begin
      m_act = 0; m_low = !m_low; m_cnt = 0;
    end else if (cv) begin
      if (mode_intr) watch_hit = !m_act && (m_low ? cold : hot);
      else           watch_hit = m_act ? cold : hot;
      if (!watch_hit) m_cnt = 0;
      else if (m_cnt + 1 >= run_len(fault_sel)) begin
        m_cnt = 0;
        if (mode_intr) begin m_act = 1; m_cause = !m_low; end
        else           begin m_act = !m_act; m_cause = m_act; end
      end else m_cnt++;
    end
    m_sd_prev = shutdown;
    m_mode_prev = mode_intr;
    e.pin = pol_high ? m_act : !m_act;
    e.cause = m_cause;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    conv_done = 0; reg_read = 0; ara_win = 0; gc_reset = 0;
  endtask

  task automatic conv(input logic [11:0] t, input string tag);
    step(1, t, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, '0, 0, 0, 0, tag);
  endtask

  // monitor: compares each queued item one register stage later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        tests++;
        if (alert_pin !== e.pin || alert_cause !== e.cause) begin
          fails++;
          $display("FAIL %s: pin=%b cause=%b expected pin=%b cause=%b",
                   e.tag, alert_pin, alert_cause, e.pin, e.cause);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (alert_pin !== 1'b1 || alert_cause !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: pin=%b cause=%b expected pin=1 cause=0", alert_pin, alert_cause);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1 idle after reset");

    // comparator mode, single fault
    conv(12'h4FF, "R3 just below high");
    conv(12'h500, "R3 equal to high asserts");
    conv(12'h4B0, "R4 between limits holds");
    conv(12'h700, "R4 hot while active holds");
    conv(12'h4AF, "R4 below low releases R12");

    // fault run of 2
    fault_sel = 2'd1;
    conv(12'h600, "R2 first fault");
    conv(12'h100, "R2 break restarts");
    conv(12'h600, "R2 first again");
    conv(12'h600, "R2 second fault asserts");
    // run of 6 to release
    fault_sel = 2'd3;
    for (int i = 0; i < 5; i++) conv(12'h100, "R2 five cold not enough");
    conv(12'h100, "R2 sixth cold releases");
    fault_sel = 2'd2;
    for (int i = 0; i < 3; i++) conv(12'h7F0, "R2 three hot of four");
    conv(12'h7F0, "R2 fourth hot asserts");

    // polarity and comparator-mode reads
    pol_high = 1'b1;
    idle("R8 active high pin");
    step(0, '0, 1, 0, 0, "R7 read ignored");
    step(0, '0, 0, 1, 0, "R7 alert reply ignored");
    pol_high = 1'b0;
    idle("R8 active low pin");

    // interrupt mode
    gc_reset = 0;
    step(0, '0, 0, 0, 1, "R10 general-call clears");
    fault_sel = 2'd0;
    mode_intr = 1'b1;
    idle("R13 mode change");
    conv(12'h500, "R5 interrupt assert");
    conv(12'h100, "R5 cold conversion holds");
    step(0, '0, 1, 0, 0, "R5 read clears");
    conv(12'h600, "R6 hot ignored after clear");
    conv(12'h4AF, "R6 below low asserts R12");
    step(0, '0, 0, 1, 0, "R5 alert reply clears");
    conv(12'h100, "R6 cold ignored after rearm");
    conv(12'h700, "R6 back to high watch R12");

    // shutdown entry
    shutdown = 1'b1;
    idle("R9 shutdown entry clears");
    shutdown = 1'b0;
    idle("R9 leave shutdown");
    conv(12'h700, "R9 hot after shutdown");
    step(0, '0, 0, 0, 1, "R10 general-call clears active");
    mode_intr = 1'b0;
    idle("R13 back to comparator");

    // signed and full-width comparisons
    hi_lim = 12'hFFC; lo_lim = 12'hE70;
    conv(12'hFFB, "R11 -0.3125 below -0.25");
    conv(12'h004, "R11 +0.25 at or above -0.25");
    conv(12'hE70, "R11 equal to low holds");
    conv(12'hE6F, "R11 below negative low releases");
    hi_lim = 12'h501; lo_lim = 12'h4B0;
    conv(12'h500, "R11 low bits matter");
    conv(12'h501, "R11 exact match asserts");
    conv(12'h4A0, "R11 release");

    // mode change restarts count
    fault_sel = 2'd1;
    conv(12'h600, "R13 one fault counted");
    mode_intr = 1'b1;
    idle("R13 switch to interrupt");
    conv(12'h600, "R13 count restarted");
    conv(12'h600, "R13 second fault asserts");
    idle("R13 settle");

    done = 1'b1;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule